// File: doc/BRIEF.md
# Seven-by-Seven Window Mean Unit

This block computes the average intensity of square 7x7 pixel windows without a divider. The 49 pixels of a window are added, the total is scaled by the fixed constant 1337, and the product is shifted right by 16 places. The result is about the total divided by 49.017, which is within roughly 0.03% of an exact divide by 49.

Each accepted input carries two things. The first is a strip of 7 rows by 14 columns from the search image, which holds eight horizontally adjacent windows. The second is a separate 7x7 reference window. Every accepted input gives eight strip means and one reference mean. Vertical column totals are shared by neighbouring windows. The unit is fully pipelined, takes a new input on every cycle, and has a fixed latency. A valid strobe travels with the data.

Top module: `win_mean_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `valid_o` is 0. All mean outputs are 0 after reset until the first result arrives.
- R2: Strip pixel (row r, column c) sits at bits `[(r*14+c)*8 +: 8]` of `right_pix_i`. Mean k, at bits `[k*8 +: 8]` of `right_mean_o`, equals floor(S*1337 / 65536). S is the sum of rows 0..6 and columns k..k+6 of the strip.
- R3: Reference pixel (r, c) sits at bits `[(r*7+c)*8 +: 8]` of `ref_pix_i`. `ref_mean_o` equals floor(S*1337 / 65536), where S is the sum of all 49 reference pixels.
- R4: `valid_o` is high exactly 4 clock edges after each edge at which `valid_i` was high. Back-to-back inputs give back-to-back results.
- R5: The mean outputs change only on a cycle where `valid_o` is high. Pixel data presented while `valid_i` is low has no effect on any output.
- R6: The result is truncated, not rounded. All-255 windows give 254, all-zero windows give 0, and no mean ever exceeds 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input strip and reference window are valid this cycle |
| right_pix_i | input | 784 | 7x14 strip, 8-bit pixels, row-major |
| ref_pix_i | input | 392 | 7x7 reference window, 8-bit pixels, row-major |
| valid_o | output | 1 | Means are new this cycle |
| right_mean_o | output | 64 | Eight strip-window means, window k at bits k*8 |
| ref_mean_o | output | 8 | Reference-window mean |

## Verification
Two faults are hard to expose from the ports: a window that picks up one column too many or too few, and a scale step that rounds instead of truncating. Smooth random images hide both. The stimulus therefore sets single bright pixels at the strip's corner columns, so exactly one window sees each pixel. It also drives saturated and empty windows, where truncation must give 254 and 0. Results are compared while idle cycles carry random pixel data, so any leak of invalid input into the held outputs is caught. A reset is also asserted while results are still in flight.

// File: rtl/mean_pkg.sv
package mean_pkg;
    localparam int DEF_PIX_W  = 8;
    localparam int DEF_WIN    = 7;
    localparam int DEF_NWIN   = 8;
    localparam int DEF_RECIP  = 1337;
    localparam int DEF_SHIFT  = 16;
    // column sum, window sum, multiply, shift/output
    localparam int PIPE_DEPTH = 4;

    typedef enum int {
        STG_COL = 0,
        STG_WIN = 1,
        STG_MUL = 2,
        STG_OUT = 3
    } stage_e;
endpackage

// File: rtl/mean_colsum.sv
module mean_colsum #(
    parameter int PIX_W = 8,
    parameter int ROWS  = 7,
    parameter int NCOL  = 14,
    parameter int COL_W = 11
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic [ROWS*NCOL*PIX_W-1:0]  pix_i,
    output logic [NCOL*COL_W-1:0]       col_o
);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [COL_W-1:0] acc;
        logic [COL_W-1:0] col_q;

        always_comb begin
            acc = '0;
            for (int r = 0; r < ROWS; r++) begin
                acc = acc + COL_W'(pix_i[(r*NCOL+c)*PIX_W +: PIX_W]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst)     col_q <= '0;
            else if (en) col_q <= acc;
        end

        assign col_o[c*COL_W +: COL_W] = col_q;
    end
endmodule

// File: rtl/mean_rowsum.sv
module mean_rowsum #(
    parameter int COL_W = 11,
    parameter int WIN   = 7,
    parameter int NWIN  = 8,
    parameter int SUM_W = 14,
    localparam int NCOL = WIN + NWIN - 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [NCOL*COL_W-1:0]  col_i,
    output logic [NWIN*SUM_W-1:0]  sum_o
);
    for (genvar k = 0; k < NWIN; k++) begin : g_win
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] sum_q;

        always_comb begin
            acc = '0;
            for (int j = 0; j < WIN; j++) begin
                acc = acc + SUM_W'(col_i[(k+j)*COL_W +: COL_W]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst)     sum_q <= '0;
            else if (en) sum_q <= acc;
        end

        assign sum_o[k*SUM_W +: SUM_W] = sum_q;
    end
endmodule

// File: rtl/mean_scale.sv
module mean_scale #(
    parameter int          SUM_W   = 14,
    parameter int          N       = 9,
    parameter int          RECIP   = 1337,
    parameter int          SHIFT   = 16,
    parameter int          OUT_W   = 8,
    parameter int unsigned MAX_SUM = 12495,
    localparam int         PROD_W  = SUM_W + $clog2(RECIP + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_mul,
    input  logic                 en_out,
    input  logic [N*SUM_W-1:0]   sum_i,
    output logic [N*OUT_W-1:0]   mean_o
);
    localparam longint unsigned MAX_MEAN =
        (longint'(MAX_SUM) * longint'(RECIP)) >> SHIFT;

    for (genvar k = 0; k < N; k++) begin : g_lane
        logic [PROD_W-1:0] prod_q;
        logic [OUT_W-1:0]  mean_q;

        always_ff @(posedge clk) begin
            if (rst)         prod_q <= '0;
            else if (en_mul) prod_q <= PROD_W'(sum_i[k*SUM_W +: SUM_W]) * PROD_W'(RECIP);
        end

        always_ff @(posedge clk) begin
            if (rst)         mean_q <= '0;
            else if (en_out) mean_q <= prod_q[SHIFT +: OUT_W];
        end

        assign mean_o[k*OUT_W +: OUT_W] = mean_q;

        assert_mean_range_R6: assert property (@(posedge clk) disable iff (rst)
            en_out |=> (mean_q <= OUT_W'(MAX_MEAN)));
    end
endmodule

// File: rtl/win_mean_unit.sv
module win_mean_unit
    import mean_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    parameter int NWIN  = DEF_NWIN,
    parameter int RECIP = DEF_RECIP,
    parameter int SHIFT = DEF_SHIFT,
    localparam int STRIP   = WIN + NWIN - 1,
    localparam int PIX_MAX = (1 << PIX_W) - 1,
    localparam int COL_W   = $clog2(WIN * PIX_MAX + 1),
    localparam int SUM_W   = $clog2(WIN * WIN * PIX_MAX + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         valid_i,
    input  logic [WIN*STRIP*PIX_W-1:0]   right_pix_i,
    input  logic [WIN*WIN*PIX_W-1:0]     ref_pix_i,
    output logic                         valid_o,
    output logic [NWIN*PIX_W-1:0]        right_mean_o,
    output logic [PIX_W-1:0]             ref_mean_o
);
    localparam int unsigned MAX_SUM = WIN * WIN * PIX_MAX;

    logic [PIPE_DEPTH-1:0]   vpipe;
    logic [STRIP*COL_W-1:0]  rcol;
    logic [WIN*COL_W-1:0]    lcol;
    logic [NWIN*SUM_W-1:0]   rsum;
    logic [SUM_W-1:0]        lsum;
    logic [(NWIN+1)*PIX_W-1:0] means;

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[PIPE_DEPTH-2:0], valid_i};
    end

    mean_colsum #(.PIX_W(PIX_W), .ROWS(WIN), .NCOL(STRIP), .COL_W(COL_W)) u_col_right (
        .clk(clk), .rst(rst), .en(valid_i), .pix_i(right_pix_i), .col_o(rcol));

    mean_colsum #(.PIX_W(PIX_W), .ROWS(WIN), .NCOL(WIN), .COL_W(COL_W)) u_col_ref (
        .clk(clk), .rst(rst), .en(valid_i), .pix_i(ref_pix_i), .col_o(lcol));

    mean_rowsum #(.COL_W(COL_W), .WIN(WIN), .NWIN(NWIN), .SUM_W(SUM_W)) u_win_right (
        .clk(clk), .rst(rst), .en(vpipe[STG_COL]), .col_i(rcol), .sum_o(rsum));

    mean_rowsum #(.COL_W(COL_W), .WIN(WIN), .NWIN(1), .SUM_W(SUM_W)) u_win_ref (
        .clk(clk), .rst(rst), .en(vpipe[STG_COL]), .col_i(lcol), .sum_o(lsum));

    mean_scale #(.SUM_W(SUM_W), .N(NWIN+1), .RECIP(RECIP), .SHIFT(SHIFT),
                 .OUT_W(PIX_W), .MAX_SUM(MAX_SUM)) u_scale (
        .clk(clk), .rst(rst), .en_mul(vpipe[STG_WIN]), .en_out(vpipe[STG_MUL]),
        .sum_i({lsum, rsum}), .mean_o(means));

    assign valid_o      = vpipe[STG_OUT];
    assign right_mean_o = means[NWIN*PIX_W-1:0];
    assign ref_mean_o   = means[NWIN*PIX_W +: PIX_W];

    // R1: nothing valid right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !valid_o);

    // R4: fixed latency of four edges, in both directions
    assert_latency_fwd_R4: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> ##4 valid_o);
    assert_latency_back_R4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(valid_i, 4));

    // R5: means only move together with a valid result
    assert_hold_right_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(right_mean_o) |-> valid_o);
    assert_hold_ref_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_mean_o) |-> valid_o);
endmodule

// File: tb/win_mean_unit_tb_top.sv
module win_mean_unit_tb_top;
    localparam int PW = 8;
    localparam int W  = 7;
    localparam int NW = 8;
    localparam int SC = W + NW - 1;

    logic clk = 0;
    logic rst = 1;
    logic vin = 0;
    logic [W*SC*PW-1:0] rp = '0;
    logic [W*W*PW-1:0]  lp = '0;
    logic               valid_o;
    logic [NW*PW-1:0]   right_mean_o;
    logic [PW-1:0]      ref_mean_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    win_mean_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(vin),
        .right_pix_i(rp), .ref_pix_i(lp),
        .valid_o(valid_o), .right_mean_o(right_mean_o), .ref_mean_o(ref_mean_o));

    // ---------------- behavioural reference ----------------
    function automatic int mean_of(input int s);
        return (s * 1337) / 65536;
    endfunction

    int mm [3][NW+1];
    bit mv [3];
    int em [NW+1];
    bit ev;

    task automatic model_compute(output int res [NW+1]);
        for (int k = 0; k < NW; k++) begin
            int s = 0;
            for (int r = 0; r < W; r++)
                for (int c = k; c < k + W; c++)
                    s += rp[(r*SC+c)*PW +: PW];
            res[k] = mean_of(s);
        end
        begin
            int s = 0;
            for (int r = 0; r < W; r++)
                for (int c = 0; c < W; c++)
                    s += lp[(r*W+c)*PW +: PW];
            res[NW] = mean_of(s);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            ev = 0;
            for (int i = 0; i < 3; i++) mv[i] = 0;
            for (int k = 0; k <= NW; k++) em[k] = 0;
        end else begin
            ev = mv[2];
            if (mv[2]) em = mm[2];
            mv[2] = mv[1]; mm[2] = mm[1];
            mv[1] = mv[0]; mm[1] = mm[0];
            mv[0] = vin;
            if (vin) model_compute(mm[0]);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(valid_o == ev, "R4 valid_o", valid_o, ev);
            for (int k = 0; k < NW; k++)
                check(right_mean_o[k*PW +: PW] == em[k],
                      ev ? "R2 strip mean" : "R5 strip hold",
                      right_mean_o[k*PW +: PW], em[k]);
            check(ref_mean_o == em[NW], ev ? "R3 ref mean" : "R5 ref hold",
                  ref_mean_o, em[NW]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic fill(input int mode, input int val);
        // mode 0 constant, 1 random, 2 ramp
        for (int i = 0; i < W*SC; i++)
            rp[i*PW +: PW] = (mode == 0) ? val[7:0] : (mode == 1) ? 8'($urandom) : 8'(i * 3 + val);
        for (int i = 0; i < W*W; i++)
            lp[i*PW +: PW] = (mode == 0) ? val[7:0] : (mode == 1) ? 8'($urandom) : 8'(i * 5 + val);
    endtask

    task automatic step(input bit v);
        vin = v;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check(valid_o == 0, "R1 valid in reset", valid_o, 0);
        check(right_mean_o == 0, "R1 strip means in reset", int'(right_mean_o[31:0]), 0);
        check(ref_mean_o == 0, "R1 ref mean in reset", ref_mean_o, 0);
        rst = 0;
        step(0); step(0);

        // R6: empty and saturated windows
        fill(0, 0);   step(1);
        fill(0, 255); step(1);
        step(0); step(0); step(0); step(0);

        // R5: garbage while invalid
        for (int i = 0; i < 6; i++) begin fill(1, 0); step(0); end

        // R2: single bright pixel at corner columns, window boundaries
        fill(0, 0); rp[(6*SC+13)*PW +: PW] = 8'd255; step(1);
        fill(0, 0); rp[(0*SC+0)*PW +: PW]  = 8'd255; step(1);
        fill(0, 0); rp[(3*SC+6)*PW +: PW]  = 8'd200; rp[(3*SC+7)*PW +: PW] = 8'd100; step(1);
        // R3: single bright reference pixel
        fill(0, 0); lp[(6*W+6)*PW +: PW] = 8'd255; step(1);
        // ramp pattern
        fill(2, 1); step(1);
        fill(2, 77); step(1);

        // R4: back-to-back random stream
        for (int i = 0; i < 40; i++) begin fill(1, 0); step(1); end
        // random gaps
        for (int i = 0; i < 200; i++) begin fill(1, 0); step(($urandom % 3) != 0); end

        // R1: reset with results in flight
        fill(1, 0); step(1); fill(1, 0); step(1);
        rst = 1; vin = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        step(0);
        check(valid_o == 0, "R1 valid after mid-run reset", valid_o, 0);
        check(ref_mean_o == 0, "R1 ref mean after mid-run reset", ref_mean_o, 0);
        for (int i = 0; i < 20; i++) begin fill(1, 0); step(1); end
        for (int i = 0; i < 8; i++) step(0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule